// File: doc/BRIEF.md
# Phase-Disposition Multicarrier PWM Level Modulator

This block drives the nine gate signals of a reduced-switch multilevel inverter that draws on three DC sources. Every system clock it compares one signed reference sample with a stack of in-phase triangular carriers. The number of carriers that the reference strictly exceeds, less half the carrier count, gives a signed output level. A per-mode table then turns that level into a nine-bit switch state.

A single mode input picks one of two operating modes. The first is seven-level operation, with six carriers and equal source voltages. The second is fifteen-level operation, with fourteen carriers and unequal source voltages. One up/down counter produces one triangle. Each carrier is that triangle shifted by a whole multiple of the band height, so all carriers share frequency, amplitude and phase. The band height is derived from the system clock and the 5 kHz carrier frequency.

The reference comes from outside the block, already scaled so that ±(levels−1)/2 band heights spans the output range. Dead time and the power stage are handled elsewhere.

Top module: `pdpwm_top`

## Requirements
- R1: While reset is asserted, and in the cycle it is released, `gateOut` is all zero, `levelOut` is 0 and `modeActive` is 0 (seven-level mode).
- R2: The common triangle value T starts at 0 after reset. It rises by one per clock up to BAND = CLK_HZ/(2*CARRIER_HZ), then falls by one per clock back to 0, giving a period of 2*BAND clocks. With `modeActive`=0 and a reference of 0, `levelOut` is therefore -1 exactly when it was computed at the peak, and 0 otherwise.
- R3: With H = 7 in fifteen-level mode and H = 3 in seven-level mode, carrier k (k = 0..2H−1) has the value T + (k−H)*BAND. One clock after a sample is presented, `levelOut` equals the number of carriers that the reference strictly exceeds, minus H. The T and mode used are the values held before that edge.
- R4: A reference above every carrier gives level +H, and one at or below every carrier gives −H. The level never leaves ±H of the mode it was computed in.
- R5: `modeActive` loads `modeSel` only on a clock edge at which T equals BAND. On every other edge it holds its value.
- R6: `gateOut` bit 8 is S1 and bit 0 is S9. A level computed in fifteen-level mode maps to S1..S9 as follows. +7=011001010, +6=010101010, +5=100101010, +4=011001100, +3=010101100, +2=100101100, +1=011010010, 0=010101001, −1=100101001, −2=011010100, −3=101010100, −4=100110100, −5=011010001, −6=101010001, −7=100110001.
- R7: A level computed in seven-level mode maps to S1..S9 as follows. +3=011001001, +2=011001100, +1=011010010, 0=101010010, −1=100101001, −2=100110100, −3=100110001.
- R8: `gateOut` is registered. It shows the decode of the `levelOut` value from the previous cycle, decoded with the mode that level was computed in, so it changes only on a clock edge.
- R9: From the second edge after reset onward, S1≠S2, S3≠S4 and S5≠S6, and exactly one of S7, S8, S9 is on.
- R10: For a seven-level level above zero, S1=0 and S2=1. For one below zero, S1=1 and S2=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refSample | input | REF_W | Signed reference sample, in carrier-band units |
| modeSel | input | 1 | Requested mode: 1 = fifteen-level, 0 = seven-level |
| gateOut | output | 9 | Switch states, S1 at bit 8 down to S9 at bit 0 |
| levelOut | output | 4 | Signed output level, registered |
| modeActive | output | 1 | Mode currently applied to the carriers |

## Verification
The bench builds the block with CLK_HZ = 80 kHz, which gives a band height of 8 clocks and a carrier period of 16 clocks, and with REF_W = 8. With these values every level in both tables appears within a few hundred cycles. A reference lands exactly on a carrier value often enough to exercise the strict-exceed rule. Many carrier peaks pass during a run, so mode requests arriving in mid-slope can be seen waiting for the next peak. An 8-bit reference also reaches well beyond ±7 bands, which drives saturation in both modes.

// File: rtl/pdpwm_pkg.sv
package pdpwm_pkg;
  localparam int MAX_CARRIERS = 14;
  localparam int LEVEL_W      = 4;
  localparam int GATE_W       = 9;

  typedef struct packed {
    logic       fullScale;  // 1: fourteen carriers, 0: six
    logic [2:0] halfCnt;    // carriers per half-stack in force
  } pwmCtrl_t;
endpackage

// File: rtl/pdpwm_ctrl.sv
module pdpwm_ctrl
  import pdpwm_pkg::*;
#(
  parameter int BAND  = 256,
  parameter int TRI_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSel,
  output logic [TRI_W-1:0] triVal,
  output pwmCtrl_t         ctl
);
  logic [TRI_W-1:0] triQ;
  logic             risingQ;
  logic             modeQ;
  logic             atPeak;

  assign atPeak = (triQ == TRI_W'(BAND));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      triQ    <= '0;
      risingQ <= 1'b1;
    end else if (risingQ) begin
      triQ <= triQ + 1'b1;
      if (triQ == TRI_W'(BAND - 1)) risingQ <= 1'b0;
    end else begin
      triQ <= triQ - 1'b1;
      if (triQ == TRI_W'(1)) risingQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       modeQ <= 1'b0;
    else if (atPeak) modeQ <= modeSel;
  end

  assign triVal        = triQ;
  assign ctl.fullScale = modeQ;
  assign ctl.halfCnt   = modeQ ? 3'd7 : 3'd3;

  p_tri_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    triQ <= TRI_W'(BAND));
  p_tri_turn_r2: assert property (@(posedge clk) disable iff (!rstN)
    (triQ == TRI_W'(BAND)) |=> (triQ == TRI_W'(BAND - 1)));
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (triQ != TRI_W'(BAND)) |=> $stable(modeQ));
endmodule

// File: rtl/pdpwm_decoder.sv
module pdpwm_decoder
  import pdpwm_pkg::*;
(
  input  logic signed [LEVEL_W-1:0] level,
  input  logic                      fullScale,
  output logic [GATE_W-1:0]         pattern
);
  // pattern[8] = S1 ... pattern[0] = S9
  always_comb begin
    pattern = '0;
    if (fullScale) begin
      case (level)
        4'sd7:  pattern = 9'b011001010;
        4'sd6:  pattern = 9'b010101010;
        4'sd5:  pattern = 9'b100101010;
        4'sd4:  pattern = 9'b011001100;
        4'sd3:  pattern = 9'b010101100;
        4'sd2:  pattern = 9'b100101100;
        4'sd1:  pattern = 9'b011010010;
        4'sd0:  pattern = 9'b010101001;
        -4'sd1: pattern = 9'b100101001;
        -4'sd2: pattern = 9'b011010100;
        -4'sd3: pattern = 9'b101010100;
        -4'sd4: pattern = 9'b100110100;
        -4'sd5: pattern = 9'b011010001;
        -4'sd6: pattern = 9'b101010001;
        -4'sd7: pattern = 9'b100110001;
        default: pattern = '0;
      endcase
    end else begin
      case (level)
        4'sd3:  pattern = 9'b011001001;
        4'sd2:  pattern = 9'b011001100;
        4'sd1:  pattern = 9'b011010010;
        4'sd0:  pattern = 9'b101010010;
        -4'sd1: pattern = 9'b100101001;
        -4'sd2: pattern = 9'b100110100;
        -4'sd3: pattern = 9'b100110001;
        default: pattern = '0;
      endcase
    end
  end
endmodule

// File: rtl/pdpwm_datapath.sv
module pdpwm_datapath
  import pdpwm_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int BAND  = 256,
  parameter int TRI_W = 9
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic signed [REF_W-1:0]   refSample,
  input  logic [TRI_W-1:0]          triVal,
  input  pwmCtrl_t                  ctl,
  output logic signed [LEVEL_W-1:0] levelOut,
  output logic [GATE_W-1:0]         gateOut
);
  localparam int SPAN_W = TRI_W + 3;
  localparam int CMP_W  = ((REF_W > SPAN_W) ? REF_W : SPAN_W) + 2;

  logic signed [CMP_W-1:0] refExt;
  logic signed [CMP_W-1:0] triExt;
  logic [MAX_CARRIERS-1:0] above;

  assign refExt = CMP_W'(refSample);
  assign triExt = signed'(CMP_W'(triVal));

  for (genvar k = 0; k < MAX_CARRIERS; k++) begin : g_carrier
    localparam int OFF_FULL = (k - 7) * BAND;
    localparam int OFF_HALF = (k - 3) * BAND;
    localparam bit IN_HALF  = (k < 6);
    logic signed [CMP_W-1:0] offs;
    logic signed [CMP_W-1:0] carVal;
    always_comb begin
      offs     = ctl.fullScale ? CMP_W'(OFF_FULL) : CMP_W'(OFF_HALF);
      carVal   = triExt + offs;
      above[k] = (ctl.fullScale || IN_HALF) && (refExt > carVal);
    end
  end

  logic [3:0]        nAbove;
  logic signed [4:0] lvlWide;
  always_comb begin
    nAbove = '0;
    for (int i = 0; i < MAX_CARRIERS; i++) nAbove = nAbove + {3'b000, above[i]};
    lvlWide = $signed({1'b0, nAbove}) - $signed({2'b00, ctl.halfCnt});
  end

  logic signed [LEVEL_W-1:0] levelQ;
  logic                      lvModeQ;
  logic [GATE_W-1:0]         pattern;
  logic [GATE_W-1:0]         gateQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ  <= '0;
      lvModeQ <= 1'b0;
    end else begin
      levelQ  <= lvlWide[LEVEL_W-1:0];
      lvModeQ <= ctl.fullScale;
    end
  end

  pdpwm_decoder u_dec (
    .level    (levelQ),
    .fullScale(lvModeQ),
    .pattern  (pattern)
  );

  always_ff @(posedge clk) begin
    if (!rstN) gateQ <= '0;
    else       gateQ <= pattern;
  end

  assign levelOut = levelQ;
  assign gateOut  = gateQ;

  p_level_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    lvModeQ ? (levelQ >= -4'sd7 && levelQ <= 4'sd7) : (levelQ >= -4'sd3 && levelQ <= 4'sd3));
  p_legs_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (gateQ[8] != gateQ[7] && gateQ[6] != gateQ[5] && gateQ[4] != gateQ[3]));
  p_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ($countones(gateQ[2:0]) == 1));
  p_pos_sign_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(lvModeQ) && $past(levelQ) > 4'sd0) |-> (gateQ[8:7] == 2'b01));
  p_neg_sign_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(lvModeQ) && $past(levelQ) < 4'sd0) |-> (gateQ[8:7] == 2'b10));
endmodule

// File: rtl/pdpwm_top.sv
module pdpwm_top
  import pdpwm_pkg::*;
#(
  parameter int CLK_HZ     = 2_560_000,
  parameter int CARRIER_HZ = 5_000,
  parameter int REF_W      = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic signed [REF_W-1:0]   refSample,
  input  logic                      modeSel,
  output logic [GATE_W-1:0]         gateOut,
  output logic signed [LEVEL_W-1:0] levelOut,
  output logic                      modeActive
);
  localparam int BAND  = CLK_HZ / (2 * CARRIER_HZ);
  localparam int TRI_W = $clog2(BAND + 1);

  logic [TRI_W-1:0] triVal;
  pwmCtrl_t         ctl;

  pdpwm_ctrl #(.BAND(BAND), .TRI_W(TRI_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .modeSel(modeSel),
    .triVal (triVal),
    .ctl    (ctl)
  );

  pdpwm_datapath #(.REF_W(REF_W), .BAND(BAND), .TRI_W(TRI_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .refSample(refSample),
    .triVal   (triVal),
    .ctl      (ctl),
    .levelOut (levelOut),
    .gateOut  (gateOut)
  );

  assign modeActive = ctl.fullScale;
endmodule

// File: tb/sim_pdpwm_top.sv
module sim_pdpwm_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 80_000;
  localparam int CARRIER_HZ = 5_000;
  localparam int REF_W      = 8;
  localparam int BAND       = CLK_HZ / (2 * CARRIER_HZ);

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic signed [REF_W-1:0] refSample = '0;
  logic                    modeSel = 1'b0;
  logic [8:0]              gateOut;
  logic signed [3:0]       levelOut;
  logic                    modeActive;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pdpwm_top #(.CLK_HZ(CLK_HZ), .CARRIER_HZ(CARRIER_HZ), .REF_W(REF_W)) u0 (
    .clk(clk), .rstN(rstN), .refSample(refSample), .modeSel(modeSel),
    .gateOut(gateOut), .levelOut(levelOut), .modeActive(modeActive)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model of the requirements
  int         mTri;
  bit         mUp;
  bit         mMode;
  int         mLevel;
  bit         mLvMode;
  logic [8:0] mGates;
  int         mGLevel;
  bit         mGMode;
  bit         mGValid;

  function automatic int expLevel(int r, int t, bit full);
    int h = full ? 7 : 3;
    int c = 0;
    for (int k = 0; k < 2 * h; k++) if (r > t + (k - h) * BAND) c++;
    return c - h;
  endfunction

  function automatic logic [8:0] expGates(int lv, bit full);
    if (full) begin
      case (lv)
        7: return 9'b011001010;   6: return 9'b010101010;
        5: return 9'b100101010;   4: return 9'b011001100;
        3: return 9'b010101100;   2: return 9'b100101100;
        1: return 9'b011010010;   0: return 9'b010101001;
        -1: return 9'b100101001;  -2: return 9'b011010100;
        -3: return 9'b101010100;  -4: return 9'b100110100;
        -5: return 9'b011010001;  -6: return 9'b101010001;
        -7: return 9'b100110001;  default: return 9'b0;
      endcase
    end else begin
      case (lv)
        3: return 9'b011001001;   2: return 9'b011001100;
        1: return 9'b011010010;   0: return 9'b101010010;
        -1: return 9'b100101001;  -2: return 9'b100110100;
        -3: return 9'b100110001;  default: return 9'b0;
      endcase
    end
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // called at a falling edge: check, drive, advance model across next rising edge
  task automatic step(int r, bit m, string lvTag);
    int nL;
    logic [8:0] nG;
    bit nM;
    check(int'(levelOut) == mLevel, lvTag, "levelOut", int'(levelOut), mLevel);
    check(gateOut == mGates, mLvMode ? "R6,R8" : "R7,R8", "gateOut", int'(gateOut), int'(mGates));
    check(modeActive == mMode, "R5", "modeActive", int'(modeActive), int'(mMode));
    if (mGValid) begin
      check((gateOut[8] != gateOut[7]) && (gateOut[6] != gateOut[5]) && (gateOut[4] != gateOut[3])
            && ($countones(gateOut[2:0]) == 1), "R9", "gate legs", int'(gateOut), int'(mGates));
      if (!mGMode && mGLevel != 0)
        check(gateOut[8:7] == ((mGLevel > 0) ? 2'b01 : 2'b10), "R10", "S1S2",
              int'(gateOut[8:7]), (mGLevel > 0) ? 1 : 2);
    end
    refSample = REF_W'(r);
    modeSel   = m;
    nL = expLevel(r, mTri, mMode);
    nG = expGates(mLevel, mLvMode);
    nM = (mTri == BAND) ? m : mMode;
    mGLevel = mLevel; mGMode = mLvMode; mGValid = 1'b1;
    mGates = nG; mLvMode = mMode; mLevel = nL; mMode = nM;
    if (mUp) begin mTri++; if (mTri == BAND) mUp = 1'b0; end
    else begin mTri--; if (mTri == 0) mUp = 1'b1; end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired, actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20714));
    mTri = 0; mUp = 1'b1; mMode = 1'b0; mLevel = 0; mLvMode = 1'b0;
    mGates = '0; mGLevel = 0; mGMode = 1'b0; mGValid = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(gateOut == 9'b0, "R1", "gateOut in reset", int'(gateOut), 0);
    check(levelOut == 4'sd0, "R1", "levelOut in reset", int'(levelOut), 0);
    check(modeActive == 1'b0, "R1", "modeActive in reset", int'(modeActive), 0);
    rstN = 1'b1;
    // R2: zero reference in seven-level mode marks each peak with level -1
    for (int i = 0; i < 4 * BAND + 3; i++) step(0, 1'b0, "R2");
    // R4: saturation, seven-level
    for (int i = 0; i < 2 * BAND; i++) step(127, 1'b0, "R4");
    for (int i = 0; i < 2 * BAND; i++) step(-128, 1'b0, "R4");
    // R5: request fifteen-level in mid-slope, must wait for peak
    for (int i = 0; i < 3 * BAND; i++) step(5, 1'b1, "R3");
    // R4: saturation, fifteen-level
    for (int i = 0; i < 2 * BAND; i++) step(127, 1'b1, "R4");
    for (int i = 0; i < 2 * BAND; i++) step(-128, 1'b1, "R4");
    // R3/R6: slow sweep across the whole fifteen-level range, on carrier edges
    for (int r = -64; r <= 64; r++) begin
      step(r, 1'b1, "R3");
      step(r, 1'b1, "R3");
    end
    // R3/R7: slow sweep across the seven-level range
    for (int i = 0; i < 3 * BAND; i++) step(0, 1'b0, "R5");
    for (int r = -32; r <= 32; r++) begin
      step(r, 1'b0, "R3");
      step(r, 1'b0, "R3");
      step(r, 1'b0, "R3");
    end
    // random references with occasional mode requests
    begin
      bit m = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        int r;
        if ($urandom_range(0, 39) == 0) m = ~m;
        r = (m ? $urandom_range(0, 135) - 68 : $urandom_range(0, 67) - 34);
        if ($urandom_range(0, 15) == 0) r = $urandom_range(0, 255) - 128;
        step(r, m, "R3");
      end
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule